// File: doc/BRIEF.md
# Flash Erase-Block Map and Protection Guard

This block sits beside the command decoder of a 2 MByte serial flash. It takes a 21-bit byte address and reports which erase block holds it: the block's base address, a size code, and whether that block may be written and read. The block sizes depend on where the address falls. Each end of the array holds four 8 KByte parameter blocks and one 32 KByte block. Thirty 64 KByte blocks fill the space between the two ends. A 4 KByte sector always lies inside exactly one of these blocks, so a sector erase is judged by the protection of the block that holds the sector.

The block keeps a 48-bit protection register. Each 8 KByte block has two bits in it, one that blocks writes and one that blocks reads. Every other block has one bit that blocks writes. The register accepts a partial write of one to six bytes, a global unlock that clears every bit, and a lock-down strobe. After lock-down the register is frozen until reset. When the guard configuration input is high and the write-protect pin is low, register writes are refused.

A small state machine holds the lock state. `ST_OPEN` is the state after reset, and the register accepts writes and the global unlock in it. `ST_OPEN` moves to `ST_LOCKED` on the cycle after a lock strobe. `ST_LOCKED` has no exit. Only reset brings the machine back to `ST_OPEN`. The address query and the request check are combinational and follow the current register value with no delay.

Top module: `flash_block_guard`

## Requirements
- R1: After reset the lock state is `ST_OPEN` and the register holds 48'h00FF_FFFF_FFFF, so every block is write-protected and no block is read-protected.
- R2: Addresses 0x000000–0x007FFF and 0x1F8000–0x1FFFFF map to 8 KByte blocks. For these, `q_size` is 0 and `q_base` is the address with bits 12:0 cleared.
- R3: Addresses 0x008000–0x00FFFF and 0x1F0000–0x1F7FFF map to 32 KByte blocks. For these, `q_size` is 1 and `q_base` is 0x008000 or 0x1F0000 respectively.
- R4: Every other address maps to a 64 KByte block. For these, `q_size` is 2 and `q_base` is the address with bits 15:0 cleared.
- R5: The write-protect bits sit at fixed positions. Bit i (0..29) guards the 64 KByte block whose base is 0x010000 + i·0x10000. Bit 30 guards the low 32 KByte block and bit 31 guards the high one. Bits 32..35 guard the low 8 KByte blocks in ascending address order, and bits 36..39 guard the high ones in the same order. `q_write_ok` is the inverse of the selected bit.
- R6: Bits 40..47 are read-protect bits for the 8 KByte blocks, in the same order as bits 32..39. `q_read_ok` is low only when the address lies in an 8 KByte block whose read bit is set.
- R7: For `q_op` values 0 (program), 1 (sector erase) and 2 (block erase), `q_req_ok` equals `q_write_ok`. For 3 (chip erase), `q_req_ok` is high only if bits 39:0 are all clear; read bits do not matter.
- R8: A register write replaces the low `bpr_wr_bytes` bytes (byte 0 = bits 7:0) from `bpr_wr_data` and keeps the rest. A count of 0 changes nothing. A count above 6 acts as 6.
- R9: When `wp_guard_en` is 1 and `wp_n` is 0, register writes are ignored. The global unlock is not affected by these pins.
- R10: In `ST_OPEN`, a global unlock clears all 48 register bits on the next cycle.
- R11: After a lock strobe in `ST_OPEN`, writes and unlocks are ignored until reset. Reset returns the block to `ST_OPEN` with the R1 value.
- R12: If a write and an unlock come in the same cycle, the write wins. A write in the same cycle as the lock strobe still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bpr_wr | input | 1 | Register write strobe |
| bpr_wr_data | input | 48 | Write data, byte 0 in bits 7:0 |
| bpr_wr_bytes | input | 3 | Number of low bytes to replace |
| bpr_lock | input | 1 | Lock-down strobe |
| bpr_unlock | input | 1 | Global unlock strobe |
| wp_n | input | 1 | Write-protect pin, active low |
| wp_guard_en | input | 1 | Configuration bit that lets `wp_n` act |
| q_addr | input | 21 | Query byte address |
| q_op | input | 2 | Request kind: 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| bpr_q | output | 48 | Current register value |
| q_base | output | 21 | Base address of the block that holds `q_addr` |
| q_size | output | 2 | 0 = 8 KByte, 1 = 32 KByte, 2 = 64 KByte |
| q_write_ok | output | 1 | The addressed block is not write-protected |
| q_read_ok | output | 1 | The addressed block is not read-protected |
| q_req_ok | output | 1 | The request given by `q_op` is allowed |

## Verification
The checker assumes that the strobes are sampled only at rising edges. It also assumes that any change to `q_addr` and `q_op` settles before the edge, because the query outputs are checked as combinational functions of them. The bench meets both assumptions: it changes every input at the falling edge and holds each strobe high for exactly one cycle. It also raises a write and an unlock together only in the R12 tests. That keeps the checker's frozen-register and WP-guard properties free of cases where the write-over-unlock priority decides the outcome.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    localparam int ADDR_W       = 21;
    localparam int SMALL_SH     = 13;
    localparam int MID_SH       = 15;
    localparam int BIG_SH       = 16;
    localparam int N_SMALL_SIDE = 4;

    localparam int SM_W      = $clog2(N_SMALL_SIDE);
    localparam int BLK_W     = ADDR_W - BIG_SH;
    localparam int BIG_COUNT = (1 << BLK_W) - 2;
    localparam int W_MID_BOT = BIG_COUNT;
    localparam int W_MID_TOP = BIG_COUNT + 1;
    localparam int W_SMALL0  = BIG_COUNT + 2;
    localparam int R_SMALL0  = W_SMALL0 + 2 * N_SMALL_SIDE;
    localparam int PROT_W    = R_SMALL0 + 2 * N_SMALL_SIDE;
    localparam int IDX_W     = $clog2(PROT_W);
    localparam int N_BYTES   = PROT_W / 8;
    localparam int CNT_W     = $clog2(N_BYTES + 1);

    localparam logic [PROT_W-1:0] WRITE_MASK =
        {{(PROT_W - R_SMALL0){1'b0}}, {R_SMALL0{1'b1}}};
    localparam logic [PROT_W-1:0] PROT_RESET = WRITE_MASK;

    typedef enum logic [1:0] {
        SZ_SMALL = 2'd0,
        SZ_MID   = 2'd1,
        SZ_BIG   = 2'd2
    } blk_size_e;

    typedef enum logic [1:0] {
        OP_PROGRAM      = 2'd0,
        OP_SECTOR_ERASE = 2'd1,
        OP_BLOCK_ERASE  = 2'd2,
        OP_CHIP_ERASE   = 2'd3
    } req_op_e;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;
endpackage

// File: rtl/fbg_block_decode.sv
module fbg_block_decode
    import fbg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] base,
    output blk_size_e         size,
    output logic [IDX_W-1:0]  widx,
    output logic [IDX_W-1:0]  ridx,
    output logic              has_rbit
);
    localparam logic [ADDR_W-1:0] M_SMALL = ~ADDR_W'((1 << SMALL_SH) - 1);
    localparam logic [ADDR_W-1:0] M_MID   = ~ADDR_W'((1 << MID_SH) - 1);
    localparam logic [ADDR_W-1:0] M_BIG   = ~ADDR_W'((1 << BIG_SH) - 1);

    logic [BLK_W-1:0] blk;
    logic [SM_W-1:0]  sub;
    logic             at_bot, at_top, in_small;
    int               side_off;

    assign blk      = addr[ADDR_W-1:BIG_SH];
    assign sub      = addr[SMALL_SH +: SM_W];
    assign at_bot   = (blk == '0);
    assign at_top   = &blk;
    assign in_small = at_bot ? !addr[MID_SH] : addr[MID_SH];
    assign side_off = at_top ? N_SMALL_SIDE : 0;

    always_comb begin
        base     = addr & M_BIG;
        size     = SZ_BIG;
        widx     = IDX_W'(int'(blk) - 1);
        ridx     = '0;
        has_rbit = 1'b0;
        if (at_bot || at_top) begin
            if (in_small) begin
                base     = addr & M_SMALL;
                size     = SZ_SMALL;
                widx     = IDX_W'(W_SMALL0 + side_off + int'(sub));
                ridx     = IDX_W'(R_SMALL0 + side_off + int'(sub));
                has_rbit = 1'b1;
            end else begin
                base = addr & M_MID;
                size = SZ_MID;
                widx = at_top ? IDX_W'(W_MID_TOP) : IDX_W'(W_MID_BOT);
            end
        end
    end
endmodule

// File: rtl/fbg_prot_reg.sv
module fbg_prot_reg
    import fbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [PROT_W-1:0] wr_data,
    input  logic [2:0]        wr_bytes,
    input  logic              lock,
    input  logic              unlock,
    input  logic              wp_n,
    input  logic              wp_guard_en,
    output logic [PROT_W-1:0] prot_q,
    output logic              locked
);
    lock_state_e       state, state_nxt;
    logic [PROT_W-1:0] merged, prot_nxt;
    logic [CNT_W-1:0]  eff_n;
    logic              wr_allowed;

    assign eff_n      = (int'(wr_bytes) > N_BYTES) ? CNT_W'(N_BYTES) : CNT_W'(wr_bytes);
    assign wr_allowed = wr && !(wp_guard_en && !wp_n);

    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        assign merged[b*8 +: 8] = (b < int'(eff_n)) ? wr_data[b*8 +: 8] : prot_q[b*8 +: 8];
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OPEN:   if (lock) state_nxt = ST_LOCKED;
            ST_LOCKED: state_nxt = ST_LOCKED;
            default:   state_nxt = ST_OPEN;
        endcase
    end

    // register-value logic
    always_comb begin
        prot_nxt = prot_q;
        unique case (state)
            ST_OPEN: begin
                if (wr_allowed)  prot_nxt = merged;
                else if (unlock) prot_nxt = '0;
            end
            ST_LOCKED: prot_nxt = prot_q;
            default:   prot_nxt = prot_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prot_q <= PROT_RESET;
        else        prot_q <= prot_nxt;
    end

    assign locked = (state == ST_LOCKED);
endmodule

// File: rtl/fbg_permit.sv
module fbg_permit
    import fbg_pkg::*;
(
    input  logic [PROT_W-1:0] prot,
    input  logic [IDX_W-1:0]  widx,
    input  logic [IDX_W-1:0]  ridx,
    input  logic              has_rbit,
    input  req_op_e           op,
    output logic              write_ok,
    output logic              read_ok,
    output logic              req_ok
);
    logic any_write_prot;

    assign any_write_prot = |(prot & WRITE_MASK);
    assign write_ok       = !prot[widx];
    assign read_ok        = !(has_rbit && prot[ridx]);

    always_comb begin
        unique case (op)
            OP_PROGRAM, OP_SECTOR_ERASE, OP_BLOCK_ERASE: req_ok = write_ok;
            OP_CHIP_ERASE:                               req_ok = !any_write_prot;
            default:                                     req_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/flash_block_guard.sv
module flash_block_guard
    import fbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bpr_wr,
    input  logic [PROT_W-1:0] bpr_wr_data,
    input  logic [2:0]        bpr_wr_bytes,
    input  logic              bpr_lock,
    input  logic              bpr_unlock,
    input  logic              wp_n,
    input  logic              wp_guard_en,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [1:0]        q_op,
    output logic [PROT_W-1:0] bpr_q,
    output logic [ADDR_W-1:0] q_base,
    output logic [1:0]        q_size,
    output logic              q_write_ok,
    output logic              q_read_ok,
    output logic              q_req_ok
);
    blk_size_e        size_e;
    logic [IDX_W-1:0] widx, ridx;
    logic             has_rbit;
    logic             locked_w;

    fbg_prot_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (bpr_wr),
        .wr_data     (bpr_wr_data),
        .wr_bytes    (bpr_wr_bytes),
        .lock        (bpr_lock),
        .unlock      (bpr_unlock),
        .wp_n        (wp_n),
        .wp_guard_en (wp_guard_en),
        .prot_q      (bpr_q),
        .locked      (locked_w)
    );

    fbg_block_decode u_dec (
        .addr     (q_addr),
        .base     (q_base),
        .size     (size_e),
        .widx     (widx),
        .ridx     (ridx),
        .has_rbit (has_rbit)
    );

    fbg_permit u_perm (
        .prot     (bpr_q),
        .widx     (widx),
        .ridx     (ridx),
        .has_rbit (has_rbit),
        .op       (req_op_e'(q_op)),
        .write_ok (q_write_ok),
        .read_ok  (q_read_ok),
        .req_ok   (q_req_ok)
    );

    assign q_size = size_e;
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker
    import fbg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bpr_wr,
    input logic              bpr_unlock,
    input logic              wp_n,
    input logic              wp_guard_en,
    input logic              locked,
    input logic [PROT_W-1:0] bpr_q,
    input logic [ADDR_W-1:0] q_addr,
    input logic [ADDR_W-1:0] q_base,
    input logic [1:0]        q_size,
    input logic [1:0]        q_op,
    input logic              q_read_ok,
    input logic              q_req_ok
);
    logic [ADDR_W:0] span;
    always_comb begin
        case (q_size)
            2'd0:    span = (ADDR_W+1)'(1 << SMALL_SH);
            2'd1:    span = (ADDR_W+1)'(1 << MID_SH);
            default: span = (ADDR_W+1)'(1 << BIG_SH);
        endcase
    end

    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_locked_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(bpr_q));

    assert_wp_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_guard_en && !wp_n && !bpr_unlock) |=> $stable(bpr_q));

    assert_unlock_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && bpr_unlock && !bpr_wr) |=> (bpr_q == '0));

    assert_read_only_small_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_size != 2'd0) |-> q_read_ok);

    assert_chip_needs_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_op == 2'd3 && q_req_ok) |-> ((bpr_q & WRITE_MASK) == '0));

    assert_base_contains_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_addr >= q_base) && ({1'b0, q_addr - q_base} < span));
endmodule

bind flash_block_guard fbg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bpr_wr      (bpr_wr),
    .bpr_unlock  (bpr_unlock),
    .wp_n        (wp_n),
    .wp_guard_en (wp_guard_en),
    .locked      (locked_w),
    .bpr_q       (bpr_q),
    .q_addr      (q_addr),
    .q_base      (q_base),
    .q_size      (q_size),
    .q_op        (q_op),
    .q_read_ok   (q_read_ok),
    .q_req_ok    (q_req_ok)
);

// File: tb/flash_block_guard_test.sv
module flash_block_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;
    localparam logic [47:0] RST_VAL = 48'h00FF_FFFF_FFFF;

    // {addr, base, size, write bit, read bit (63 = none)}
    localparam logic [55:0] VEC [NV] = '{
        {21'h000000, 21'h000000, 2'd0, 6'd32, 6'd40},
        {21'h001FFF, 21'h000000, 2'd0, 6'd32, 6'd40},
        {21'h002000, 21'h002000, 2'd0, 6'd33, 6'd41},
        {21'h007FFF, 21'h006000, 2'd0, 6'd35, 6'd43},
        {21'h008000, 21'h008000, 2'd1, 6'd30, 6'd63},
        {21'h00FFFF, 21'h008000, 2'd1, 6'd30, 6'd63},
        {21'h010000, 21'h010000, 2'd2, 6'd0,  6'd63},
        {21'h01ABCD, 21'h010000, 2'd2, 6'd0,  6'd63},
        {21'h123456, 21'h120000, 2'd2, 6'd17, 6'd63},
        {21'h1EFFFF, 21'h1E0000, 2'd2, 6'd29, 6'd63},
        {21'h1F0000, 21'h1F0000, 2'd1, 6'd31, 6'd63},
        {21'h1F7FFF, 21'h1F0000, 2'd1, 6'd31, 6'd63},
        {21'h1F8000, 21'h1F8000, 2'd0, 6'd36, 6'd44},
        {21'h1FA001, 21'h1FA000, 2'd0, 6'd37, 6'd45},
        {21'h1FFFFF, 21'h1FE000, 2'd0, 6'd39, 6'd47}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bpr_wr = 0;
    logic [47:0] bpr_wr_data = '0;
    logic [2:0]  bpr_wr_bytes = '0;
    logic        bpr_lock = 0;
    logic        bpr_unlock = 0;
    logic        wp_n = 1;
    logic        wp_guard_en = 0;
    logic [20:0] q_addr = '0;
    logic [1:0]  q_op = '0;
    logic [47:0] bpr_q;
    logic [20:0] q_base;
    logic [1:0]  q_size;
    logic        q_write_ok, q_read_ok, q_req_ok;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_block_guard uut (
        .clk(clk), .rst_n(rst_n), .bpr_wr(bpr_wr), .bpr_wr_data(bpr_wr_data),
        .bpr_wr_bytes(bpr_wr_bytes), .bpr_lock(bpr_lock), .bpr_unlock(bpr_unlock),
        .wp_n(wp_n), .wp_guard_en(wp_guard_en), .q_addr(q_addr), .q_op(q_op),
        .bpr_q(bpr_q), .q_base(q_base), .q_size(q_size), .q_write_ok(q_write_ok),
        .q_read_ok(q_read_ok), .q_req_ok(q_req_ok)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic w, input logic [47:0] d, input logic [2:0] n,
                         input logic lk, input logic ul);
        @(negedge clk);
        bpr_wr = w; bpr_wr_data = d; bpr_wr_bytes = n; bpr_lock = lk; bpr_unlock = ul;
        @(negedge clk);
        bpr_wr = 0; bpr_lock = 0; bpr_unlock = 0;
    endtask

    task automatic query(input logic [20:0] a, input logic [1:0] op);
        q_addr = a; q_op = op;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset value", 64'(bpr_q), 64'(RST_VAL));
        query(21'h000000, 2'd0);
        chk("R1 reset write-protected", 64'(q_write_ok), 64'd0);
        chk("R1 reset not read-protected", 64'(q_read_ok), 64'd1);

        // table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            logic [20:0] a, b;
            logic [1:0]  s;
            logic [5:0]  w, r;
            string tg;
            {a, b, s, w, r} = VEC[i];
            tg = (s == 2'd0) ? "R2" : (s == 2'd1) ? "R3" : "R4";
            pulse(1, 48'(1) << w, 3'd6, 0, 0);
            query(a, 2'd0);
            chk({tg, " base"}, 64'(q_base), 64'(b));
            chk({tg, " size"}, 64'(q_size), 64'(s));
            chk("R5 own bit blocks write", 64'(q_write_ok), 64'd0);
            chk("R7 program refused", 64'(q_req_ok), 64'd0);
            pulse(1, ~(48'(1) << w), 3'd6, 0, 0);
            query(a, 2'd2);
            chk("R5 other bits do not block", 64'(q_write_ok), 64'd1);
            chk("R6 read permit", 64'(q_read_ok), (r == 6'd63) ? 64'd1 : 64'd0);
            chk("R7 block erase allowed", 64'(q_req_ok), 64'd1);
        end

        // R7 chip erase ignores read bits
        pulse(1, 48'hFF00_0000_0000, 3'd6, 0, 0);
        query(21'h000000, 2'd3);
        chk("R7 chip erase with read bits only", 64'(q_req_ok), 64'd1);
        chk("R6 read bit blocks read", 64'(q_read_ok), 64'd0);
        pulse(1, 48'hFF00_0000_0001, 3'd6, 0, 0);
        query(21'h000000, 2'd3);
        chk("R7 chip erase refused", 64'(q_req_ok), 64'd0);
        query(21'h010800, 2'd1);
        chk("R7 sector erase in protected block", 64'(q_req_ok), 64'd0);

        // R10 unlock
        pulse(0, '0, 3'd0, 0, 1);
        chk("R10 unlock clears", 64'(bpr_q), 64'd0);

        // R8 byte counts
        pulse(1, 48'h1234_5678_9ABC, 3'd6, 0, 0);
        chk("R8 six bytes", 64'(bpr_q), 64'h1234_5678_9ABC);
        pulse(1, 48'hFFFF_FFFF_FFFF, 3'd2, 0, 0);
        chk("R8 two bytes", 64'(bpr_q), 64'h1234_5678_FFFF);
        pulse(1, 48'h0, 3'd0, 0, 0);
        chk("R8 zero bytes", 64'(bpr_q), 64'h1234_5678_FFFF);
        pulse(1, 48'hA5A5_A5A5_A5A5, 3'd7, 0, 0);
        chk("R8 count 7 acts as 6", 64'(bpr_q), 64'hA5A5_A5A5_A5A5);

        // R9 write-protect pin
        wp_guard_en = 1; wp_n = 0;
        pulse(1, 48'h0, 3'd6, 0, 0);
        chk("R9 guarded write ignored", 64'(bpr_q), 64'hA5A5_A5A5_A5A5);
        wp_n = 1;
        pulse(1, 48'h0, 3'd1, 0, 0);
        chk("R9 pin high allows", 64'(bpr_q), 64'hA5A5_A5A5_A500);
        wp_guard_en = 0; wp_n = 0;
        pulse(1, 48'h0, 3'd2, 0, 0);
        chk("R9 guard off allows", 64'(bpr_q), 64'hA5A5_A5A5_0000);
        wp_guard_en = 1;
        pulse(0, '0, 3'd0, 0, 1);
        chk("R9 unlock not guarded", 64'(bpr_q), 64'd0);
        wp_guard_en = 0; wp_n = 1;

        // R12 same-cycle priority
        pulse(1, 48'h1111_1111_1111, 3'd6, 0, 1);
        chk("R12 write beats unlock", 64'(bpr_q), 64'h1111_1111_1111);
        pulse(1, 48'h2222_2222_2222, 3'd6, 1, 0);
        chk("R12 write with lock lands", 64'(bpr_q), 64'h2222_2222_2222);

        // R11 locked
        pulse(1, 48'h0, 3'd6, 0, 0);
        chk("R11 locked write ignored", 64'(bpr_q), 64'h2222_2222_2222);
        pulse(0, '0, 3'd0, 0, 1);
        chk("R11 locked unlock ignored", 64'(bpr_q), 64'h2222_2222_2222);
        query(21'h020000, 2'd0);
        chk("R11 locked protection active", 64'(q_write_ok), 64'd0);
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 reset restores value", 64'(bpr_q), 64'(RST_VAL));
        pulse(1, 48'h0, 3'd6, 0, 0);
        chk("R11 reset reopens", 64'(bpr_q), 64'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule